// File: doc/BRIEF.md
# MSI Capability Register Block

This block holds the configuration-space registers of a message signaled interrupt capability. Software reaches it through a dword-addressed configuration port with byte enables. Any access that lands inside the capability window is decoded to one register slot. The window starts at a dword base set by a parameter. Writes go through per-field masks, so software can change only the bits the capability defines as writable. Reads return the live contents, and unimplemented bits read as zero.

Three build options set the shape of the block: the number of vectors (a power of two from 1 to 32), support for a 64-bit message address, and support for per-vector masking. These options fix the window length and the dword slot of each field. The interrupt generator sees the enable bit, the allocated vector count, the message address, the message data and the mask. It sends pending-bit set and clear requests back to the block.

Top module: `msi_cap_regs`

## Requirements
- R1: The first window dword reads as {7'b0, mask-capable, 64-bit-capable, enabled-count field[2:0] at bits 22:20, capable-count field[2:0] at bits 19:17, enable at bit 16, next pointer[7:0], 8'h05}. The capable field holds log2 of the vector count.
- R2: In the first dword, only the enable bit (16) and the enabled-count field (22:20) can be written, and only when byte enable 2 is set. All other bits there keep their values.
- R3: A write of an enabled-count value above the capable value stores the capable value.
- R4: Address low sits at relative dword 1, and its bits 1:0 always read zero. Address high sits at relative dword 2, is fully writable, and exists only when 64-bit support is built. Without it, the upper 32 bits of the address are zero.
- R5: The 16-bit data field sits at relative dword 3 with 64-bit support and at relative dword 2 without it. Bits 31:16 of that dword read zero.
- R6: The mask sits in the dword after the data, with the pending register in the dword after that. Only the low N bits of the mask are writable for N vectors. Without masking support, the mask and pending registers are absent and read zero.
- R7: Software writes to pending have no effect. A pending bit sets on pend_set and clears on pend_clr. When both arrive for the same bit in the same cycle, clear wins.
- R8: After any write inside the window that leaves enable at 1 (with masking support), pending bits at positions at or above the allocated vector count are cleared. With enable at 0, pending is left alone.
- R9: The window is 3, 4, 5 or 6 dwords long for the four option combinations: 32-bit unmasked, 64-bit unmasked, 32-bit masked, 64-bit masked. Writes outside it change nothing. Reads outside it, and any read data while cfg_rd is low, return zero.
- R10: Reset clears enable, the enabled-count field, address low and high, data, mask and pending.
- R11: msi_vec_alloc equals 1 shifted left by the enabled-count field. msi_addr is {address high, address low}, and the other generator outputs mirror their registers.
- R12: A write updates only the bytes whose byte enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | CFG_AW | Dword address |
| cfg_be | input | 4 | Byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, combinational from cfg_rd and cfg_addr |
| msi_enable | output | 1 | Enable bit |
| msi_vec_alloc | output | 6 | Allocated vector count |
| msi_addr | output | 64 | Message address |
| msi_data | output | 16 | Message data |
| msi_mask | output | NV | Per-vector mask |
| msi_pend | output | NV | Pending bits |
| pend_set | input | NV | Pending set requests from the generator |
| pend_clr | input | NV | Pending clear requests from the generator |

## Verification
The assertions take for granted that pend_set and pend_clr are clean one-cycle requests. They also assume cfg_wr and cfg_rd never address a dword whose index overflows the port. Beyond that, a write outside the window is expected to leave every generator output untouched unless a pending request comes in the same cycle. The stimulus never raises pending requests during an outside write, and it keeps every address within 6 bits. Two builds are driven from the same port: a 64-bit masked one and a 32-bit unmasked one at a separate base. Together they exercise both slot layouts.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

  typedef enum logic [2:0] {
    SL_NONE, SL_CTRL, SL_ALO, SL_AHI, SL_DATA, SL_MASK, SL_PEND
  } slot_e;

  localparam logic [7:0] CAP_ID = 8'h05;

  // capability length in bytes for the four option combinations
  function automatic int cap_bytes(input bit a64, input bit pvm);
    if (a64 && pvm) return 24;
    if (pvm)        return 20;
    if (a64)        return 14;
    return 10;
  endfunction

  function automatic int cap_dwords(input bit a64, input bit pvm);
    return (cap_bytes(a64, pvm) + 3) / 4;
  endfunction

endpackage

// File: rtl/msi_cap_decode.sv
module msi_cap_decode
  import msi_cap_pkg::*;
#(
  parameter int CFG_AW  = 6,
  parameter int BASE_DW = 20,
  parameter bit ADDR64  = 1'b1,
  parameter bit PVM     = 1'b1
) (
  input  logic [CFG_AW-1:0] addr,
  output slot_e             slot
);
  localparam int NDW = cap_dwords(ADDR64, PVM);

  logic [CFG_AW-1:0] rel;
  logic              in_win;

  assign rel    = addr - CFG_AW'(BASE_DW);
  assign in_win = (addr >= CFG_AW'(BASE_DW)) && (int'(rel) < NDW);

  always_comb begin
    slot = SL_NONE;
    if (in_win) begin
      case (int'(rel))
        0:       slot = SL_CTRL;
        1:       slot = SL_ALO;
        2:       slot = ADDR64 ? SL_AHI  : SL_DATA;
        3:       slot = ADDR64 ? SL_DATA : SL_MASK;
        4:       slot = ADDR64 ? SL_MASK : SL_PEND;
        5:       slot = SL_PEND;
        default: slot = SL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/msi_cap_store.sv
module msi_cap_store
  import msi_cap_pkg::*;
#(
  parameter int NV     = 8,
  parameter bit ADDR64 = 1'b1,
  parameter bit PVM    = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  slot_e         slot,
  input  logic [3:0]    be,
  input  logic [31:0]   wdata,
  input  logic [NV-1:0] pend_set,
  input  logic [NV-1:0] pend_clr,
  output logic          en_q,
  output logic [2:0]    mme_q,
  output logic [29:0]   alo_q,
  output logic [31:0]   ahi_q,
  output logic [15:0]   dat_q,
  output logic [NV-1:0] msk_q,
  output logic [NV-1:0] pnd_q
);
  localparam int         CAP_LOG  = $clog2(NV);
  localparam logic [2:0] CAP_LOG3 = 3'(CAP_LOG);

  logic          hit, ctrl_ce, alo_ce, ahi_ce, dat_ce, msk_ce;
  logic          en_d;
  logic [2:0]    mme_d;
  logic [29:0]   alo_d;
  logic [31:0]   ahi_d;
  logic [15:0]   dat_d;
  logic [NV-1:0] msk_d, pnd_d, keep;

  assign hit     = wr && (slot != SL_NONE);
  assign ctrl_ce = wr && (slot == SL_CTRL) && be[2];
  assign alo_ce  = wr && (slot == SL_ALO);
  assign ahi_ce  = wr && (slot == SL_AHI);
  assign dat_ce  = wr && (slot == SL_DATA);
  assign msk_ce  = wr && (slot == SL_MASK);

  // next-state logic
  always_comb begin
    en_d  = en_q;
    mme_d = mme_q;
    if (ctrl_ce) begin
      en_d  = wdata[16];
      mme_d = (wdata[22:20] > CAP_LOG3) ? CAP_LOG3 : wdata[22:20];
    end
    alo_d = alo_q;
    for (int i = 2; i < 32; i++)
      if (be[i/8]) alo_d[i-2] = wdata[i];
    ahi_d = ahi_q;
    for (int i = 0; i < 32; i++)
      if (be[i/8]) ahi_d[i] = wdata[i];
    dat_d = dat_q;
    for (int i = 0; i < 16; i++)
      if (be[i/8]) dat_d[i] = wdata[i];
    msk_d = msk_q;
    for (int i = 0; i < NV; i++)
      if (be[i/8]) msk_d[i] = wdata[i];
    for (int i = 0; i < NV; i++)
      keep[i] = (32'(i) < (32'd1 << mme_d));
    pnd_d = (pnd_q | pend_set) & ~pend_clr;
    if (hit && en_d) pnd_d = pnd_d & keep;
  end

  // register processes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      mme_q <= 3'd0;
    end else if (ctrl_ce) begin
      en_q  <= en_d;
      mme_q <= mme_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      alo_q <= '0;
    else if (alo_ce) alo_q <= alo_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dat_q <= '0;
    else if (dat_ce) dat_q <= dat_d;
  end

  generate
    if (ADDR64) begin : g_ahi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ahi_q <= '0;
        else if (ahi_ce) ahi_q <= ahi_d;
      end
    end else begin : g_no_ahi
      assign ahi_q = '0;
    end

    if (PVM) begin : g_pvm
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      msk_q <= '0;
        else if (msk_ce) msk_q <= msk_d;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pnd_q <= '0;
        else        pnd_q <= pnd_d;
      end

      // R7: a pending bit can only rise through pend_set
      a_r7_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_set == '0) |=> ((pnd_q & ~$past(pnd_q)) == '0));
      // R7: a clear request leaves its bit low
      a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_clr != '0) |=> ((pnd_q & $past(pend_clr)) == '0));
      // R8: nothing pending beyond the allocation after a window write while enabled
      a_r8_trim: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (!en_q || ((32'(pnd_q) >> (32'd1 << mme_q)) == 32'd0)));
    end else begin : g_no_pvm
      assign msk_q = '0;
      assign pnd_q = '0;
    end
  endgenerate

  // R3: the enabled-count field never exceeds the capable value
  a_r3_mme_capped: assert property (@(posedge clk) disable iff (!rst_n)
    mme_q <= CAP_LOG3);
endmodule

// File: rtl/msi_cap_rdmux.sv
module msi_cap_rdmux
  import msi_cap_pkg::*;
#(
  parameter int         NV       = 8,
  parameter bit         ADDR64   = 1'b1,
  parameter bit         PVM      = 1'b1,
  parameter logic [7:0] NEXT_PTR = 8'h00
) (
  input  logic          rd,
  input  slot_e         slot,
  input  logic          en_q,
  input  logic [2:0]    mme_q,
  input  logic [29:0]   alo_q,
  input  logic [31:0]   ahi_q,
  input  logic [15:0]   dat_q,
  input  logic [NV-1:0] msk_q,
  input  logic [NV-1:0] pnd_q,
  output logic [31:0]   rdata
);
  localparam logic [2:0] CAP_LOG3 = 3'($clog2(NV));

  always_comb begin
    rdata = '0;
    if (rd) begin
      case (slot)
        SL_CTRL: rdata = {7'b0, PVM, ADDR64, mme_q, CAP_LOG3, en_q, NEXT_PTR, CAP_ID};
        SL_ALO:  rdata = {alo_q, 2'b00};
        SL_AHI:  rdata = ahi_q;
        SL_DATA: rdata = {16'h0, dat_q};
        SL_MASK: rdata = 32'(msk_q);
        SL_PEND: rdata = 32'(pnd_q);
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
  import msi_cap_pkg::*;
#(
  parameter int         NV       = 8,
  parameter bit         ADDR64   = 1'b1,
  parameter bit         PVM      = 1'b1,
  parameter int         CFG_AW   = 6,
  parameter int         BASE_DW  = 20,
  parameter logic [7:0] NEXT_PTR = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              msi_enable,
  output logic [5:0]        msi_vec_alloc,
  output logic [63:0]       msi_addr,
  output logic [15:0]       msi_data,
  output logic [NV-1:0]     msi_mask,
  output logic [NV-1:0]     msi_pend,
  input  logic [NV-1:0]     pend_set,
  input  logic [NV-1:0]     pend_clr
);
  slot_e         slot;
  logic          en_q;
  logic [2:0]    mme_q;
  logic [29:0]   alo_q;
  logic [31:0]   ahi_q;
  logic [15:0]   dat_q;
  logic [NV-1:0] msk_q, pnd_q;

  msi_cap_decode #(.CFG_AW(CFG_AW), .BASE_DW(BASE_DW), .ADDR64(ADDR64), .PVM(PVM)) u_decode (
    .addr(cfg_addr), .slot(slot)
  );

  msi_cap_store #(.NV(NV), .ADDR64(ADDR64), .PVM(PVM)) u_store (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .slot(slot), .be(cfg_be), .wdata(cfg_wdata),
    .pend_set(pend_set), .pend_clr(pend_clr),
    .en_q(en_q), .mme_q(mme_q), .alo_q(alo_q), .ahi_q(ahi_q), .dat_q(dat_q),
    .msk_q(msk_q), .pnd_q(pnd_q)
  );

  msi_cap_rdmux #(.NV(NV), .ADDR64(ADDR64), .PVM(PVM), .NEXT_PTR(NEXT_PTR)) u_rdmux (
    .rd(cfg_rd), .slot(slot), .en_q(en_q), .mme_q(mme_q), .alo_q(alo_q), .ahi_q(ahi_q),
    .dat_q(dat_q), .msk_q(msk_q), .pnd_q(pnd_q), .rdata(cfg_rdata)
  );

  assign msi_enable    = en_q;
  assign msi_vec_alloc = 6'd1 << mme_q;
  assign msi_addr      = {ahi_q, alo_q, 2'b00};
  assign msi_data      = dat_q;
  assign msi_mask      = msk_q;
  assign msi_pend      = pnd_q;

  // R9: a write outside the window leaves every generator output alone
  a_r9_outside_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && (slot == SL_NONE) && (pend_set == '0) && (pend_clr == '0)) |=>
      ($stable(msi_enable) && $stable(msi_vec_alloc) && $stable(msi_addr) &&
       $stable(msi_data) && $stable(msi_mask) && $stable(msi_pend)));
  // R11: allocated count is always a single power of two
  a_r11_alloc_pow2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> $onehot(msi_vec_alloc));
endmodule

// File: tb/msi_cap_regs_bench.sv
module msi_cap_regs_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [7:0]  pend_set = '0, pend_clr = '0;

  logic [31:0] a_rdata, b_rdata;
  logic        a_en, b_en;
  logic [5:0]  a_alloc, b_alloc;
  logic [63:0] a_addr, b_addr;
  logic [15:0] a_data, b_data;
  logic [7:0]  a_mask, a_pend;
  logic [3:0]  b_mask, b_pend;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_cap_regs #(.NV(8), .ADDR64(1'b1), .PVM(1'b1), .CFG_AW(6), .BASE_DW(20)) u_msi_cap_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(a_rdata), .msi_enable(a_en),
    .msi_vec_alloc(a_alloc), .msi_addr(a_addr), .msi_data(a_data), .msi_mask(a_mask),
    .msi_pend(a_pend), .pend_set(pend_set), .pend_clr(pend_clr)
  );

  msi_cap_regs #(.NV(4), .ADDR64(1'b0), .PVM(1'b0), .CFG_AW(6), .BASE_DW(40)) u_msi_cap_regs_b (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(b_rdata), .msi_enable(b_en),
    .msi_vec_alloc(b_alloc), .msi_addr(b_addr), .msi_data(b_data), .msi_mask(b_mask),
    .msi_pend(b_pend), .pend_set(pend_set[3:0]), .pend_clr(pend_clr[3:0])
  );

  // behavioural reference model of the 64-bit masked, 8-vector build at dword 20
  logic        m_en;
  logic [2:0]  m_mme;
  logic [31:0] m_alo, m_ahi;
  logic [15:0] m_data;
  logic [7:0]  m_mask, m_pend;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_mme = 0; m_alo = 0; m_ahi = 0; m_data = 0; m_mask = 0; m_pend = 0;
    end else begin
      int rel;
      logic [7:0] p;
      rel = int'(cfg_addr) - 20;
      p = (m_pend | pend_set) & ~pend_clr;
      if (cfg_wr && rel >= 0 && rel < 6) begin
        case (rel)
          0: if (cfg_be[2]) begin
               m_en = cfg_wdata[16];
               m_mme = (cfg_wdata[22:20] > 3) ? 3'd3 : cfg_wdata[22:20];
             end
          1: begin
               for (int b = 0; b < 4; b++) if (cfg_be[b]) m_alo[8*b +: 8] = cfg_wdata[8*b +: 8];
               m_alo[1:0] = 2'b00;
             end
          2: for (int b = 0; b < 4; b++) if (cfg_be[b]) m_ahi[8*b +: 8] = cfg_wdata[8*b +: 8];
          3: for (int b = 0; b < 2; b++) if (cfg_be[b]) m_data[8*b +: 8] = cfg_wdata[8*b +: 8];
          4: if (cfg_be[0]) m_mask = cfg_wdata[7:0];
          default: ;
        endcase
        if (m_en) p = p & 8'((16'd1 << (16'd1 << m_mme)) - 16'd1);
      end
      m_pend = p;
    end
  end

  function automatic logic [31:0] model_rd(input logic [5:0] a);
    int rel;
    rel = int'(a) - 20;
    case (rel)
      0: return {7'b0, 1'b1, 1'b1, m_mme, 3'd3, m_en, 8'h00, 8'h05};
      1: return m_alo;
      2: return m_ahi;
      3: return {16'h0, m_data};
      4: return {24'h0, m_mask};
      5: return {24'h0, m_pend};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check("R10/R11 enable", 64'(a_en), 64'(m_en));
      check("R11 alloc", 64'(a_alloc), 64'(6'd1 << m_mme));
      check("R11 addr", a_addr, {m_ahi, m_alo});
      check("R11 data", 64'(a_data), 64'(m_data));
      check("R6 mask", 64'(a_mask), 64'(m_mask));
      check("R7 pend", 64'(a_pend), 64'(m_pend));
      check("R9 rdata", 64'(a_rdata), cfg_rd ? 64'(model_rd(cfg_addr)) : 64'h0);
    end
  end

  task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk); #1;
    cfg_wr = 1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr = 0; cfg_be = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] va, output logic [31:0] vb);
    @(negedge clk); #1;
    cfg_rd = 1; cfg_addr = a;
    #2; va = a_rdata; vb = b_rdata;
    @(posedge clk); #1;
    cfg_rd = 0;
  endtask

  task automatic pend(input logic [7:0] s, input logic [7:0] c);
    @(negedge clk); #1;
    pend_set = s; pend_clr = c;
    @(posedge clk); #1;
    pend_set = 0; pend_clr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] va, vb;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 R1: reset contents and fixed fields
    rd(6'd20, va, vb);   check("R1 R10 ctrl after reset", 64'(va), 64'h0186_0005);
    rd(6'd21, va, vb);   check("R10 addr lo reset", 64'(va), 64'h0);
    // R3 R2: all-ones write clamps and leaves RO bits
    wr(6'd20, 4'hF, 32'hFFFF_FFFF);
    rd(6'd20, va, vb);   check("R2 R3 ctrl clamp", 64'(va), 64'h01B7_0005);
    check("R11 alloc 8", 64'(a_alloc), 64'd8);
    wr(6'd20, 4'h4, 32'h0025_0000);
    check("R11 alloc 4", 64'(a_alloc), 64'd4);
    // R2: without byte enable 2 nothing changes
    wr(6'd20, 4'hB, 32'h0000_0000);
    check("R2 be gate", 64'(a_en), 64'd1);
    // R4 R12
    wr(6'd21, 4'hF, 32'hDEAD_BEEF);
    rd(6'd21, va, vb);   check("R4 addr lo low bits", 64'(va), 64'hDEAD_BEEC);
    wr(6'd21, 4'h1, 32'h0000_00FF);
    rd(6'd21, va, vb);   check("R12 byte enable", 64'(va), 64'hDEAD_BEFC);
    wr(6'd22, 4'hF, 32'h1234_5678);
    check("R4 R11 full address", a_addr, 64'h1234_5678_DEAD_BEFC);
    // R5
    wr(6'd23, 4'hF, 32'hABCD_1234);
    rd(6'd23, va, vb);   check("R5 data dword", 64'(va), 64'h0000_1234);
    // R6
    wr(6'd24, 4'hF, 32'hFFFF_FFFF);
    rd(6'd24, va, vb);   check("R6 mask width", 64'(va), 64'h0000_00FF);
    // R7: software write to pending ignored, port sets it
    wr(6'd25, 4'hF, 32'hFFFF_FFFF);
    check("R7 sw write ignored", 64'(a_pend), 64'h0);
    pend(8'hF0, 8'h00);
    rd(6'd25, va, vb);   check("R7 pend set", 64'(va), 64'hF0);
    pend(8'h01, 8'h01);
    check("R7 clear wins", 64'(a_pend), 64'hF0);
    pend(8'h0C, 8'h00);
    // R8: trim with enable on, alloc 4
    wr(6'd23, 4'h0, 32'h0);
    check("R8 trim enabled", 64'(a_pend), 64'h0C);
    wr(6'd20, 4'h4, 32'h0020_0000);
    pend(8'hF0, 8'h00);
    wr(6'd23, 4'h0, 32'h0);
    check("R8 no trim disabled", 64'(a_pend), 64'hFC);
    // R9: outside window
    wr(6'd26, 4'hF, 32'hFFFF_FFFF);
    wr(6'd19, 4'hF, 32'hFFFF_FFFF);
    check("R9 outside write", a_addr, 64'h1234_5678_DEAD_BEFC);
    rd(6'd26, va, vb);   check("R9 outside read", 64'(va), 64'h0);
    rd(6'd19, va, vb);   check("R9 below read", 64'(va), 64'h0);
    // second build: 32-bit, unmasked, 4 vectors at dword 40
    rd(6'd40, va, vb);   check("R1 build b ctrl", 64'(vb), 64'h0004_0005);
    wr(6'd42, 4'hF, 32'h5555_AAAA);
    check("R5 build b data offset", 64'(b_data), 64'hAAAA);
    check("R4 build b no high", b_addr, 64'h0);
    rd(6'd43, va, vb);   check("R9 build b window end", 64'(vb), 64'h0);
    wr(6'd43, 4'hF, 32'hFFFF_FFFF);
    check("R6 build b no mask", 64'(b_mask), 64'h0);
    wr(6'd40, 4'h4, 32'h0070_0000);
    check("R3 build b clamp", 64'(b_alloc), 64'd4);
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule